// File: doc/BRIEF.md
# Read/Write Start Arbiter with Write Forwarding

This block sits between two request sources that share one memory array, a read requester and a write requester. On every rising clock edge it samples both select inputs and starts at most one transaction. Which one wins depends on what was started on the edge before, not on a fixed order. The winner is shown on registered grant outputs one cycle later. A loser is discarded and is not held over to a later edge.

A started write waits in an internal pending register for one cycle. It is then handed to the array as a full-burst commit, which carries the address, data and per-lane byte enables. A read may start on the edge right after a write to the same address. At that point the array still holds the old contents, so the block rebuilds the newest value. It does this lane by lane: a lane the pending write enabled takes the write data, and every other lane takes the array data.

The array reads asynchronously from the granted read address. Burst beat sequencing is handled outside this block.

Top module: `rdWrStartArb`

## Requirements
- R1: `rdGnt` and `wrGnt` are registered and change only on a rising edge. They show the decision for the inputs sampled at that edge. They are never high in the same cycle.
- R2: Suppose neither grant was high in the cycle before an edge, and both `rdSel` and `wrSel` are sampled high at that edge. Then the read is granted.
- R3: Suppose `rdGnt` was high in the cycle before an edge. If `wrSel` is high at that edge, the write is granted. A read request at that edge is dropped, and no grant follows for it later.
- R4: Suppose `wrGnt` was high in the cycle before an edge. If `rdSel` is high at that edge, the read is granted. A write request at that edge is dropped, and no grant follows for it later.
- R5: Hold both selects high continuously, starting from a cycle with no grant. The grants then alternate, one per cycle: read, write, read, write, and so on.
- R6: While `rstN` is low, `rdGnt`, `wrGnt` and `cmtEn` are low. After reset the block behaves as if nothing was started on the previous edge.
- R7: In the cycle after `wrGnt` is high, `cmtEn` is high. In that same cycle `cmtAddr`, `cmtData` and `cmtMask` carry the address, burst data and mask sampled when the write was started. In any other cycle `cmtEn` is low.
- R8: While `rdGnt` is high, `rdGntAddr` holds the `rdAddr` sampled at the start edge, and `rdData` is valid in that same cycle.
- R9: A read may start on the edge right after a write start to the same address. Burst lane i is bits [8i+7:8i], with beat 0 in the lowest 16 bits, and `wrMask` bit i = 1 means lane i is written. For every lane whose mask bit is 1, `rdData` returns the lane from that write's data.
- R10: In a forwarded read, every lane whose mask bit is 0 comes from `arrRdData`. A read that starts two or more edges after a write returns `arrRdData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all decisions on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rdSel | input | 1 | Read request for this edge |
| rdAddr | input | ADDR_W (8) | Read burst address |
| wrSel | input | 1 | Write request for this edge |
| wrAddr | input | ADDR_W (8) | Write burst address |
| wrData | input | BURST_W (64) | Write burst data, beat 0 in the low bits |
| wrMask | input | MASK_W (8) | Per-lane write enables, 1 = write lane |
| arrRdData | input | BURST_W (64) | Array contents at `rdGntAddr`, combinational |
| rdGnt | output | 1 | A read was started on the last edge |
| wrGnt | output | 1 | A write was started on the last edge |
| rdGntAddr | output | ADDR_W (8) | Address of the started read |
| rdData | output | BURST_W (64) | Coherent read burst, valid with `rdGnt` |
| cmtEn | output | 1 | Commit the pending write into the array at the next edge |
| cmtAddr | output | ADDR_W (8) | Commit address |
| cmtData | output | BURST_W (64) | Commit burst data |
| cmtMask | output | MASK_W (8) | Commit lane enables |

## Verification
Suppose the previous-start state is corrupted. The wrong grant then shows on `rdGnt` or `wrGnt` one cycle after the edge, and the following alternation stays shifted. A cycle-by-cycle comparison catches it on the first contested edge. A stale or wrong pending-write register shows as a wrong `cmtData` or `cmtMask` one cycle after `wrGnt`. A wrong forward-select shows as a wrong lane in `rdData` in the same cycle as `rdGnt`. Reads to a small address set straight after writes make both cases happen often.

// File: rtl/rdWrStartArbPkg.sv
package rdWrStartArbPkg;

  // What was started on the last edge
  typedef enum logic [1:0] {
    PREV_NONE = 2'd0,
    PREV_RD   = 2'd1,
    PREV_WR   = 2'd2
  } prevStart_e;

  // Strobes from control to datapath, valid in the cycle before the edge
  typedef struct packed {
    logic startRd;
    logic startWr;
  } startStb_t;

endpackage

// File: rtl/arbCtrl.sv
module arbCtrl
  import rdWrStartArbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdSel,
  input  logic      wrSel,
  output startStb_t stb,
  output logic      rdGnt,
  output logic      wrGnt
);

  prevStart_e prevQ;

  // Decision for the coming edge
  always_comb begin
    stb = '0;
    unique case (prevQ)
      PREV_NONE: begin
        if (rdSel)      stb.startRd = 1'b1;
        else if (wrSel) stb.startWr = 1'b1;
      end
      PREV_RD: begin
        // a second read in a row is dropped
        if (wrSel) stb.startWr = 1'b1;
      end
      PREV_WR: begin
        // a second write in a row is dropped
        if (rdSel) stb.startRd = 1'b1;
      end
      default: stb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= PREV_NONE;
      rdGnt <= 1'b0;
      wrGnt <= 1'b0;
    end else begin
      rdGnt <= stb.startRd;
      wrGnt <= stb.startWr;
      if (stb.startRd)      prevQ <= PREV_RD;
      else if (stb.startWr) prevQ <= PREV_WR;
      else                  prevQ <= PREV_NONE;
    end
  end

endmodule

// File: rtl/fwdLaneMux.sv
module fwdLaneMux #(
  parameter int LANE_W = 8
) (
  input  logic              useFwd,
  input  logic [LANE_W-1:0] arrLane,
  input  logic [LANE_W-1:0] fwdLane,
  output logic [LANE_W-1:0] outLane
);

  assign outLane = useFwd ? fwdLane : arrLane;

endmodule

// File: rtl/fwdPath.sv
module fwdPath
  import rdWrStartArbPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEATS  = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int MASK_W  = BEATS * LANES,
  localparam int BURST_W = MASK_W * LANE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  startStb_t          stb,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [BURST_W-1:0] wrData,
  input  logic [MASK_W-1:0]  wrMask,
  input  logic [BURST_W-1:0] arrRdData,
  output logic [ADDR_W-1:0]  rdGntAddr,
  output logic [BURST_W-1:0] rdData,
  output logic               cmtEn,
  output logic [ADDR_W-1:0]  cmtAddr,
  output logic [BURST_W-1:0] cmtData,
  output logic [MASK_W-1:0]  cmtMask
);

  // Write started on the previous edge, not yet in the array
  logic               pendValid;
  logic [ADDR_W-1:0]  pendAddr;
  logic [BURST_W-1:0] pendData;
  logic [MASK_W-1:0]  pendMask;

  // Forward selection captured with the read start
  logic [MASK_W-1:0]  fwdMaskQ;
  logic [BURST_W-1:0] fwdDataQ;

  logic fwdHit;
  assign fwdHit = pendValid && (pendAddr == rdAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
      pendMask  <= '0;
      cmtEn     <= 1'b0;
      cmtAddr   <= '0;
      cmtData   <= '0;
      cmtMask   <= '0;
      rdGntAddr <= '0;
      fwdMaskQ  <= '0;
      fwdDataQ  <= '0;
    end else begin
      pendValid <= stb.startWr;
      if (stb.startWr) begin
        pendAddr <= wrAddr;
        pendData <= wrData;
        pendMask <= wrMask;
      end
      cmtEn   <= pendValid;
      cmtAddr <= pendAddr;
      cmtData <= pendData;
      cmtMask <= pendMask;
      if (stb.startRd) begin
        rdGntAddr <= rdAddr;
        fwdMaskQ  <= fwdHit ? pendMask : '0;
        fwdDataQ  <= pendData;
      end
    end
  end

  for (genvar g = 0; g < MASK_W; g++) begin : gLane
    fwdLaneMux #(.LANE_W(LANE_W)) i_laneMux (
      .useFwd (fwdMaskQ[g]),
      .arrLane(arrRdData[g*LANE_W +: LANE_W]),
      .fwdLane(fwdDataQ[g*LANE_W +: LANE_W]),
      .outLane(rdData[g*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/rdWrStartArb.sv
module rdWrStartArb
  import rdWrStartArbPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEATS  = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int MASK_W  = BEATS * LANES,
  localparam int BURST_W = MASK_W * LANE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdSel,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic               wrSel,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [BURST_W-1:0] wrData,
  input  logic [MASK_W-1:0]  wrMask,
  input  logic [BURST_W-1:0] arrRdData,
  output logic               rdGnt,
  output logic               wrGnt,
  output logic [ADDR_W-1:0]  rdGntAddr,
  output logic [BURST_W-1:0] rdData,
  output logic               cmtEn,
  output logic [ADDR_W-1:0]  cmtAddr,
  output logic [BURST_W-1:0] cmtData,
  output logic [MASK_W-1:0]  cmtMask
);

  startStb_t stb;

  arbCtrl i_arbCtrl (
    .clk  (clk),
    .rstN (rstN),
    .rdSel(rdSel),
    .wrSel(wrSel),
    .stb  (stb),
    .rdGnt(rdGnt),
    .wrGnt(wrGnt)
  );

  fwdPath #(
    .ADDR_W(ADDR_W),
    .BEATS (BEATS),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) i_fwdPath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdAddr   (rdAddr),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .wrMask   (wrMask),
    .arrRdData(arrRdData),
    .rdGntAddr(rdGntAddr),
    .rdData   (rdData),
    .cmtEn    (cmtEn),
    .cmtAddr  (cmtAddr),
    .cmtData  (cmtData),
    .cmtMask  (cmtMask)
  );

endmodule

// File: rtl/rdWrStartArbChk.sv
module rdWrStartArbChk #(
  parameter int ADDR_W = 8,
  parameter int BEATS  = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int MASK_W  = BEATS * LANES,
  localparam int BURST_W = MASK_W * LANE_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               rdSel,
  input logic               wrSel,
  input logic               rdGnt,
  input logic               wrGnt,
  input logic [ADDR_W-1:0]  rdGntAddr,
  input logic [BURST_W-1:0] rdData,
  input logic [BURST_W-1:0] arrRdData,
  input logic               cmtEn,
  input logic [ADDR_W-1:0]  cmtAddr,
  input logic [BURST_W-1:0] cmtData,
  input logic [MASK_W-1:0]  cmtMask
);

  logic [BURST_W-1:0] cmtBitMask;
  for (genvar g = 0; g < MASK_W; g++) begin : gExp
    assign cmtBitMask[g*LANE_W +: LANE_W] = {LANE_W{cmtMask[g]}};
  end

  logic sameAddrHit;
  assign sameAddrHit = cmtEn && (cmtAddr == rdGntAddr);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdGnt, wrGnt})); // R1

  AST_IDLE_READ_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (!rdGnt && !wrGnt && rdSel && wrSel) |=> (rdGnt && !wrGnt)); // R2

  AST_AFTER_RD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (rdGnt && wrSel) |=> wrGnt); // R3

  AST_NO_READ_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    rdGnt |=> !rdGnt); // R3

  AST_AFTER_WR_READ: assert property (@(posedge clk) disable iff (!rstN)
    (wrGnt && rdSel) |=> rdGnt); // R4

  AST_NO_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    wrGnt |=> !wrGnt); // R4

  AST_CMT_AFTER_WR: assert property (@(posedge clk) disable iff (!rstN)
    wrGnt |=> cmtEn); // R7

  AST_CMT_ONLY_AFTER_WR: assert property (@(posedge clk) disable iff (!rstN)
    !wrGnt |=> !cmtEn); // R7

  AST_FWD_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (rdGnt && sameAddrHit) |-> (((rdData ^ cmtData) & cmtBitMask) == '0)); // R9

  AST_ARR_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (rdGnt && sameAddrHit) |-> (((rdData ^ arrRdData) & ~cmtBitMask) == '0)); // R10

  AST_NO_FWD_PLAIN: assert property (@(posedge clk) disable iff (!rstN)
    (rdGnt && !sameAddrHit) |-> (rdData == arrRdData)); // R10

endmodule

bind rdWrStartArb rdWrStartArbChk #(
  .ADDR_W(ADDR_W),
  .BEATS (BEATS),
  .LANES (LANES),
  .LANE_W(LANE_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rdSel    (rdSel),
  .wrSel    (wrSel),
  .rdGnt    (rdGnt),
  .wrGnt    (wrGnt),
  .rdGntAddr(rdGntAddr),
  .rdData   (rdData),
  .arrRdData(arrRdData),
  .cmtEn    (cmtEn),
  .cmtAddr  (cmtAddr),
  .cmtData  (cmtData),
  .cmtMask  (cmtMask)
);

// File: tb/test_rdWrStartArb.sv
`timescale 1ns/1ps
module test_rdWrStartArb;

  localparam int ADDR_W  = 8;
  localparam int MASK_W  = 8;
  localparam int BURST_W = 64;
  localparam int DEPTH   = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdSel = 1'b0, wrSel = 1'b0;
  logic [ADDR_W-1:0]  rdAddr = '0, wrAddr = '0;
  logic [BURST_W-1:0] wrData = '0;
  logic [MASK_W-1:0]  wrMask = '0;
  logic [BURST_W-1:0] arrRdData;
  logic rdGnt, wrGnt, cmtEn;
  logic [ADDR_W-1:0]  rdGntAddr, cmtAddr;
  logic [BURST_W-1:0] rdData, cmtData;
  logic [MASK_W-1:0]  cmtMask;

  always #4 clk = ~clk; // 125 MHz

  rdWrStartArb i_rdWrStartArb (
    .clk(clk), .rstN(rstN),
    .rdSel(rdSel), .rdAddr(rdAddr),
    .wrSel(wrSel), .wrAddr(wrAddr), .wrData(wrData), .wrMask(wrMask),
    .arrRdData(arrRdData),
    .rdGnt(rdGnt), .wrGnt(wrGnt), .rdGntAddr(rdGntAddr), .rdData(rdData),
    .cmtEn(cmtEn), .cmtAddr(cmtAddr), .cmtData(cmtData), .cmtMask(cmtMask)
  );

  int nChk = 0;
  int nFail = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [BURST_W-1:0] act, input logic [BURST_W-1:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [BURST_W-1:0] laneMerge(input logic [BURST_W-1:0] oldV,
      input logic [BURST_W-1:0] newV, input logic [MASK_W-1:0] m);
    logic [BURST_W-1:0] r = oldV;
    for (int i = 0; i < MASK_W; i++)
      if (m[i]) r[i*8 +: 8] = newV[i*8 +: 8];
    return r;
  endfunction

  // Physical array stand-in: async read, write on commit
  logic [BURST_W-1:0] arr [DEPTH];
  assign arrRdData = arr[rdGntAddr];
  always @(posedge clk)
    if (cmtEn) arr[cmtAddr] <= laneMerge(arr[cmtAddr], cmtData, cmtMask);

  // Behavioural reference: logical memory holds the newest data at once
  logic [BURST_W-1:0] logMem [DEPTH];
  int    prevKind = 0; // 0 none, 1 read, 2 write
  bit    expRdGnt = 0, expWrGnt = 0, expCmtEn = 0;
  logic [ADDR_W-1:0]  expRdAddr = '0, expCmtAddr = '0;
  logic [BURST_W-1:0] expRdData = '0, expCmtData = '0;
  logic [MASK_W-1:0]  expCmtMask = '0;
  bit    lastWr = 0;
  logic [ADDR_W-1:0]  lastWrAddr = '0;
  logic [BURST_W-1:0] lastWrData = '0;
  logic [MASK_W-1:0]  lastWrMask = '0;
  string gntTag = "R6", datTag = "R8";

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      arr[i] = '0;
      logMem[i] = '0;
    end
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevKind = 0; expRdGnt = 0; expWrGnt = 0; expCmtEn = 0;
      lastWr = 0; gntTag = "R6";
    end else begin
      expCmtEn   = lastWr;
      expCmtAddr = lastWrAddr;
      expCmtData = lastWrData;
      expCmtMask = lastWrMask;
      if (rdSel && wrSel)
        gntTag = (prevKind == 0) ? "R2" : (prevKind == 1) ? "R3" : "R4";
      else if (rdSel && prevKind == 1) gntTag = "R3";
      else if (wrSel && prevKind == 2) gntTag = "R4";
      else gntTag = "R1";
      expRdGnt = 0; expWrGnt = 0;
      if (prevKind != 1 && rdSel) expRdGnt = 1;
      else if (prevKind != 2 && wrSel) expWrGnt = 1;
      if (expRdGnt) begin
        expRdAddr = rdAddr;
        expRdData = logMem[rdAddr];
        datTag = (lastWr && lastWrAddr == rdAddr) ? "R9,R10" : "R8";
      end
      lastWr = expWrGnt;
      if (expWrGnt) begin
        lastWrAddr = wrAddr; lastWrData = wrData; lastWrMask = wrMask;
        logMem[wrAddr] = laneMerge(logMem[wrAddr], wrData, wrMask);
      end
      prevKind = expRdGnt ? 1 : expWrGnt ? 2 : 0;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    chk(rdGnt === expRdGnt, gntTag, rdGnt, expRdGnt);
    chk(wrGnt === expWrGnt, gntTag, wrGnt, expWrGnt);
    chk(!(rdGnt && wrGnt), "R1", {rdGnt, wrGnt}, 2'b00);
    chk(cmtEn === expCmtEn, rstN ? "R7" : "R6", cmtEn, expCmtEn);
    if (expCmtEn) begin
      chk(cmtAddr === expCmtAddr, "R7", cmtAddr, expCmtAddr);
      chk(cmtData === expCmtData, "R7", cmtData, expCmtData);
      chk(cmtMask === expCmtMask, "R7", cmtMask, expCmtMask);
    end
    if (expRdGnt) begin
      chk(rdGntAddr === expRdAddr, "R8", rdGntAddr, expRdAddr);
      chk(rdData === expRdData, datTag, rdData, expRdData);
    end
  end

  task automatic drive(input bit rs, input bit ws, input logic [ADDR_W-1:0] ra,
                       input logic [ADDR_W-1:0] wa, input logic [BURST_W-1:0] wd,
                       input logic [MASK_W-1:0] wm);
    @(negedge clk);
    #1;
    rdSel = rs; wrSel = ws; rdAddr = ra; wrAddr = wa; wrData = wd; wrMask = wm;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  endtask

  initial begin
    // R6: reset holds grants and commit low
    repeat (3) @(negedge clk);
    chk(!rdGnt && !wrGnt && !cmtEn, "R6", {rdGnt, wrGnt, cmtEn}, 3'b000);
    #1 rstN = 1'b1;

    // R5: both held from idle, same address so reads forward
    drive(1, 1, 8'h10, 8'h10, 64'h1111_2222_3333_4444, 8'hFF);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(rdGnt === (i % 2 == 0), "R5", rdGnt, (i % 2 == 0));
      chk(wrGnt === (i % 2 == 1), "R5", wrGnt, (i % 2 == 1));
      #1 wrData = wrData + 64'h0101_0101_0101_0101;
    end
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);

    // R3: back-to-back reads, the second is dropped
    drive(1, 0, 8'h10, 0, 0, 0);
    drive(1, 0, 8'h11, 0, 0, 0);
    drive(1, 0, 8'h12, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);

    // R4: back-to-back writes, the second is dropped
    drive(0, 1, 0, 8'h20, 64'hAAAA_BBBB_CCCC_DDDD, 8'hFF);
    drive(0, 1, 0, 8'h21, 64'hDEAD_BEEF_0000_1234, 8'hFF);
    drive(0, 1, 0, 8'h22, 64'h0F0F_0F0F_F0F0_F0F0, 8'hFF);
    drive(0, 0, 0, 0, 0, 0);
    drive(1, 0, 8'h21, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);

    // R9, R10: partial-mask write then read of the same address
    drive(0, 1, 0, 8'h05, 64'hFFEE_DDCC_BBAA_9988, 8'hA5);
    drive(1, 0, 8'h05, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);

    // R10: read two edges after a write is served by the array
    drive(0, 1, 0, 8'h06, 64'h7766_5544_3322_1100, 8'h3C);
    drive(0, 0, 0, 0, 0, 0);
    drive(1, 0, 8'h06, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);

    // R8: read to a different address right after a write
    drive(0, 1, 0, 8'h07, 64'h0123_4567_89AB_CDEF, 8'hFF);
    drive(1, 0, 8'h08, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);

    // Mixed traffic on a small address set
    for (int i = 0; i < 400; i++)
      drive($urandom_range(0, 1), $urandom_range(0, 1), 8'($urandom_range(0, 3)),
            8'($urandom_range(0, 3)), {$urandom, $urandom}, 8'($urandom));
    drive(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired, no requirement could complete");
    finishRun();
  end

endmodule